// File: doc/BRIEF.md
# Register-Mapped Byte Channel

This block joins a 32-bit register bus to a pair of byte streams. Software sends data by writing one of four push registers. The register chosen sets how many bytes (one to four) the write moves into a 64-byte transmit queue. Software receives data by reading one of four pop registers, which take one to four bytes from a 64-byte receive queue. A multi-byte word is always little-endian: the earliest byte in the stream sits in the lowest byte lane that holds data. Free-space and fill-count registers let software poll before it moves data. The far side of each queue is a byte port with a valid/ready handshake.

Two programmable thresholds drive two sticky interrupt flags. The transmit flag sets while free space is at or above its threshold. The receive flag sets while the fill count is at or above its threshold. A mask register gates the flags onto the interrupt outputs. Writing a one to a flag bit acknowledges it. The bit stays set only if its condition still holds. Two sticky status bits record a push that was refused and a pop that came up short.

The bus is addressed by `bus_addr[9:8]`, which selects the window (0 = data, 1 = config, 2 = interrupt), and by `bus_addr[7:0]`, the byte offset within that window. Read data comes back one cycle after the read strobe. A small response machine moves from `S_IDLE` to `S_RESP` on a read strobe. It stays in `S_RESP` while strobes keep arriving and returns to `S_IDLE` on a cycle with no strobe. `bus_rvalid` is high exactly while it is in `S_RESP`.

Top module: `bytechan_top`

## Requirements
- R1: After reset, free space reads 64, fill count reads 0, `tx_out_valid`, `bus_rvalid`, `irq_tx` and `irq_rx` are low, and `rx_in_ready` is high. The mask resets to 0 and both thresholds reset to 1.
- R2: A write to data offset 0x04, 0x08, 0x0C or 0x10 pushes 1, 2, 3 or 4 bytes, taken from `bus_wdata` with bits [7:0] as the first byte, then [15:8], and so on.
- R3: A push that asks for more bytes than the free space is dropped whole and sets sticky status bit 0. The status register is at interrupt offset 0x08, and a write of one clears a bit.
- R4: Data offset 0x14 reads free space (64 minus the transmit fill) and data offset 0x2C reads the receive fill. Both reflect an access on the very next read.
- R5: A read of data offset 0x1C, 0x20 or 0x24 pops 1, 2 or 3 bytes. Bits [7:0] hold the number delivered, and the bytes fill [15:8], [23:16] and [31:24] in stream order. A read of 0x28 pops 4 bytes into [7:0], [15:8], [23:16] and [31:24].
- R6: A pop that asks for more bytes than the fill count delivers the bytes present, returns zero in the missing lanes and sets sticky status bit 1. The count field reports the bytes actually delivered.
- R7: `tx_out_valid` is high while the transmit queue holds a byte. A byte leaves on a cycle with valid and ready both high, and the bytes leave in push order. The data is held while valid is high and ready is low.
- R8: `rx_in_ready` is low only while the receive queue holds 64 bytes. A byte offered while ready is low is not taken.
- R9: Config offset 0x00 holds the transmit threshold and 0x04 the receive threshold, and both read back. With channel index n, flag bit 2n sets when free space is at or above the transmit threshold, and bit 2n+1 sets when the fill count is at or above the receive threshold. The flag register is at interrupt offset 0x04.
- R10: Writing a one to a flag bit clears it. On the next read the bit shows set only if its condition still holds.
- R11: `irq_tx` is flag bit 2n AND mask bit 2n, and `irq_rx` is flag bit 2n+1 AND mask bit 2n+1. The mask register is at interrupt offset 0x00.
- R12: `bus_rvalid` is high in the cycle after each read strobe and low in the cycle after a cycle with no strobe, with `bus_rdata` valid while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Window select [9:8] and byte offset [7:0] |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| tx_out_valid | output | 1 | Transmit byte available |
| tx_out_ready | input | 1 | Far side takes transmit byte |
| tx_out_data | output | 8 | Transmit byte |
| rx_in_valid | input | 1 | Far side offers a receive byte |
| rx_in_ready | output | 1 | Receive queue has room |
| rx_in_data | input | 8 | Receive byte |
| irq_tx | output | 1 | Masked transmit-threshold interrupt |
| irq_rx | output | 1 | Masked receive-threshold interrupt |

## Verification
The hardest case to reach from the ports is a push that would partly fit: one byte of room left while two are requested. The stimulus gets there by holding the transmit stream stalled and filling the queue to 63 bytes with mixed push widths. It then issues a two-byte push, checks that free space is unchanged and that the status bit is set, and finally drains all 64 bytes to show that none of the refused bytes got in. A second hard case is acknowledging a flag whose condition still holds. The receive threshold is raised to two, two bytes are fed in, and the flag is acknowledged while they remain. It is acknowledged again after they are popped, to show both outcomes.

// File: rtl/bytechan_pkg.sv
package bytechan_pkg;

    localparam int ADDR_W  = 10;
    localparam int LANES   = 4;
    localparam int LANE_NW = 3;
    localparam int CNT_W   = 8;

    localparam logic [1:0] WIN_DATA = 2'd0;
    localparam logic [1:0] WIN_CFG  = 2'd1;
    localparam logic [1:0] WIN_IRQ  = 2'd2;

    localparam logic [7:0] OFS_PUSH1  = 8'h04;
    localparam logic [7:0] OFS_PUSH2  = 8'h08;
    localparam logic [7:0] OFS_PUSH3  = 8'h0C;
    localparam logic [7:0] OFS_PUSH4  = 8'h10;
    localparam logic [7:0] OFS_TXFREE = 8'h14;
    localparam logic [7:0] OFS_POP1   = 8'h1C;
    localparam logic [7:0] OFS_POP2   = 8'h20;
    localparam logic [7:0] OFS_POP3   = 8'h24;
    localparam logic [7:0] OFS_POP4   = 8'h28;
    localparam logic [7:0] OFS_RXFILL = 8'h2C;

    localparam logic [7:0] OFS_TXTHR  = 8'h00;
    localparam logic [7:0] OFS_RXTHR  = 8'h04;

    localparam logic [7:0] OFS_MASK   = 8'h00;
    localparam logic [7:0] OFS_FLAG   = 8'h04;
    localparam logic [7:0] OFS_STAT   = 8'h08;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } resp_state_t;

endpackage

// File: rtl/bytechan_fifo.sv
module bytechan_fifo
    import bytechan_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int PUSH_LANES = 4,
    parameter int HEAD_LANES = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANE_NW-1:0]        push_n,
    input  logic [8*PUSH_LANES-1:0]   push_data,
    input  logic [LANE_NW-1:0]        pop_n,
    output logic [8*HEAD_LANES-1:0]   head_data,
    output logic [$clog2(DEPTH):0]    count
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        for (int i = 0; i < PUSH_LANES; i++) begin
            if (LANE_NW'(i) < push_n) begin
                mem[wr_ptr_q + AW'(i)] <= push_data[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            wr_ptr_q <= wr_ptr_q + AW'(push_n);
            rd_ptr_q <= rd_ptr_q + AW'(pop_n);
            count_q  <= count_q + CW'(push_n) - CW'(pop_n);
        end
    end

    for (genvar g = 0; g < HEAD_LANES; g++) begin : g_head
        assign head_data[8*g +: 8] = mem[rd_ptr_q + AW'(g)];
    end

    assign count = count_q;

endmodule

// File: rtl/bytechan_regs.sv
module bytechan_regs
    import bytechan_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int CHAN_IDX = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic                   bus_rvalid,
    input  logic [$clog2(DEPTH):0] tx_count,
    input  logic [$clog2(DEPTH):0] rx_count,
    input  logic [8*LANES-1:0]     rx_head,
    output logic [LANE_NW-1:0]     tx_push_n,
    output logic [8*LANES-1:0]     tx_push_data,
    output logic [LANE_NW-1:0]     rx_pop_n,
    output logic                   irq_tx,
    output logic                   irq_rx
);

    localparam int CW  = $clog2(DEPTH) + 1;
    localparam int TXB = 2 * CHAN_IDX;
    localparam int RXB = TXB + 1;

    logic [1:0]         win;
    logic [7:0]         ofs;
    logic [LANE_NW-1:0] req_push_n;
    logic [LANE_NW-1:0] req_pop_n;
    logic [CW-1:0]      tx_free;
    logic               ovf_ev;
    logic               unf_ev;
    logic [31:0]        popped;
    logic [31:0]        pop_word;
    logic [31:0]        rd_word;
    logic [1:0]         cond;
    logic [1:0]         flag_ack;
    logic [1:0]         stat_clr;

    logic [CNT_W-1:0]   tx_thr_q;
    logic [CNT_W-1:0]   rx_thr_q;
    logic [1:0]         mask_q;
    logic [1:0]         flag_q;
    logic [1:0]         stat_q;
    logic [31:0]        rdata_q;

    resp_state_t        state_q;
    resp_state_t        state_d;

    assign win     = bus_addr[9:8];
    assign ofs     = bus_addr[7:0];
    assign tx_free = CW'(DEPTH) - tx_count;

    // width decode for data-window accesses
    always_comb begin
        req_push_n = '0;
        req_pop_n  = '0;
        if (bus_wr && win == WIN_DATA) begin
            unique case (ofs)
                OFS_PUSH1: req_push_n = 3'd1;
                OFS_PUSH2: req_push_n = 3'd2;
                OFS_PUSH3: req_push_n = 3'd3;
                OFS_PUSH4: req_push_n = 3'd4;
                default:   req_push_n = '0;
            endcase
        end
        if (bus_rd && win == WIN_DATA) begin
            unique case (ofs)
                OFS_POP1: req_pop_n = 3'd1;
                OFS_POP2: req_pop_n = 3'd2;
                OFS_POP3: req_pop_n = 3'd3;
                OFS_POP4: req_pop_n = 3'd4;
                default:  req_pop_n = '0;
            endcase
        end
    end

    // a push is all or nothing; a pop delivers what is present
    always_comb begin
        ovf_ev       = (req_push_n != '0) && (CW'(req_push_n) > tx_free);
        tx_push_n    = ovf_ev ? '0 : req_push_n;
        tx_push_data = bus_wdata;
        unf_ev       = CW'(req_pop_n) > rx_count;
        rx_pop_n     = unf_ev ? LANE_NW'(rx_count) : req_pop_n;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_pop_lane
        assign popped[8*g +: 8] = (LANE_NW'(g) < rx_pop_n) ? rx_head[8*g +: 8] : 8'h00;
    end

    assign pop_word = (req_pop_n == 3'd4) ? popped
                                          : {popped[23:0], CNT_W'(rx_pop_n)};

    always_comb begin
        rd_word = '0;
        unique case (win)
            WIN_DATA: begin
                if (ofs == OFS_TXFREE)      rd_word = 32'(tx_free);
                else if (ofs == OFS_RXFILL) rd_word = 32'(rx_count);
                else if (req_pop_n != '0)   rd_word = pop_word;
                else                        rd_word = '0;
            end
            WIN_CFG: begin
                if (ofs == OFS_TXTHR)      rd_word = 32'(tx_thr_q);
                else if (ofs == OFS_RXTHR) rd_word = 32'(rx_thr_q);
                else                       rd_word = '0;
            end
            WIN_IRQ: begin
                if (ofs == OFS_MASK)
                    rd_word = (32'(mask_q[0]) << TXB) | (32'(mask_q[1]) << RXB);
                else if (ofs == OFS_FLAG)
                    rd_word = (32'(flag_q[0]) << TXB) | (32'(flag_q[1]) << RXB);
                else if (ofs == OFS_STAT)
                    rd_word = 32'(stat_q);
                else
                    rd_word = '0;
            end
            default: rd_word = '0;
        endcase
    end

    // threshold conditions and write-one-to-clear strobes
    always_comb begin
        cond[0]  = CNT_W'(tx_free) >= tx_thr_q;
        cond[1]  = CNT_W'(rx_count) >= rx_thr_q;
        flag_ack = (bus_wr && win == WIN_IRQ && ofs == OFS_FLAG)
                   ? {bus_wdata[RXB], bus_wdata[TXB]} : 2'b00;
        stat_clr = (bus_wr && win == WIN_IRQ && ofs == OFS_STAT)
                   ? bus_wdata[1:0] : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr_q <= CNT_W'(1);
            rx_thr_q <= CNT_W'(1);
            mask_q   <= '0;
            flag_q   <= '0;
            stat_q   <= '0;
        end else begin
            if (bus_wr && win == WIN_CFG && ofs == OFS_TXTHR) tx_thr_q <= bus_wdata[CNT_W-1:0];
            if (bus_wr && win == WIN_CFG && ofs == OFS_RXTHR) rx_thr_q <= bus_wdata[CNT_W-1:0];
            if (bus_wr && win == WIN_IRQ && ofs == OFS_MASK)
                mask_q <= {bus_wdata[RXB], bus_wdata[TXB]};
            flag_q <= (flag_q & ~flag_ack) | cond;
            stat_q <= (stat_q & ~stat_clr) | {unf_ev, ovf_ev};
        end
    end

    // read response machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = bus_rd ? S_RESP : S_IDLE;
            S_RESP: state_d = bus_rd ? S_RESP : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_word;
    end

    // read response machine: outputs
    always_comb begin
        bus_rvalid = (state_q == S_RESP);
        bus_rdata  = rdata_q;
        irq_tx     = flag_q[0] & mask_q[0];
        irq_rx     = flag_q[1] & mask_q[1];
    end

endmodule

// File: rtl/bytechan_top.sv
module bytechan_top
    import bytechan_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int CHAN_IDX = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [9:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid,
    output logic        tx_out_valid,
    input  logic        tx_out_ready,
    output logic [7:0]  tx_out_data,
    input  logic        rx_in_valid,
    output logic        rx_in_ready,
    input  logic [7:0]  rx_in_data,
    output logic        irq_tx,
    output logic        irq_rx
);

    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0]      tx_count;
    logic [CW-1:0]      rx_count;
    logic [31:0]        rx_head;
    logic [LANE_NW-1:0] tx_push_n;
    logic [31:0]        tx_push_data;
    logic [LANE_NW-1:0] rx_pop_n;
    logic [LANE_NW-1:0] tx_drain_n;
    logic [LANE_NW-1:0] rx_fill_n;

    assign tx_out_valid = (tx_count != '0);
    assign rx_in_ready  = (rx_count != CW'(DEPTH));
    assign tx_drain_n   = (tx_out_valid && tx_out_ready) ? 3'd1 : 3'd0;
    assign rx_fill_n    = (rx_in_valid && rx_in_ready) ? 3'd1 : 3'd0;

    bytechan_regs #(.DEPTH(DEPTH), .CHAN_IDX(CHAN_IDX)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_rvalid   (bus_rvalid),
        .tx_count     (tx_count),
        .rx_count     (rx_count),
        .rx_head      (rx_head),
        .tx_push_n    (tx_push_n),
        .tx_push_data (tx_push_data),
        .rx_pop_n     (rx_pop_n),
        .irq_tx       (irq_tx),
        .irq_rx       (irq_rx)
    );

    bytechan_fifo #(.DEPTH(DEPTH), .PUSH_LANES(4), .HEAD_LANES(1)) tx_fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (tx_push_n),
        .push_data (tx_push_data),
        .pop_n     (tx_drain_n),
        .head_data (tx_out_data),
        .count     (tx_count)
    );

    bytechan_fifo #(.DEPTH(DEPTH), .PUSH_LANES(1), .HEAD_LANES(4)) rx_fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (rx_fill_n),
        .push_data (rx_in_data),
        .pop_n     (rx_pop_n),
        .head_data (rx_head),
        .count     (rx_count)
    );

endmodule

// File: rtl/bytechan_chk.sv
module bytechan_chk #(
    parameter int DEPTH = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_rd,
    input logic                   bus_rvalid,
    input logic                   tx_out_valid,
    input logic                   tx_out_ready,
    input logic [7:0]             tx_out_data,
    input logic                   rx_in_valid,
    input logic                   rx_in_ready,
    input logic [$clog2(DEPTH):0] tx_count,
    input logic [$clog2(DEPTH):0] rx_count,
    input logic [2:0]             tx_push_n,
    input logic [2:0]             rx_pop_n
);

    localparam int CW = $clog2(DEPTH) + 1;

    p_rvalid_follows_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    p_rvalid_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    p_push_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push_n != 3'd0) |-> (CW'(tx_push_n) <= CW'(DEPTH) - tx_count));

    p_pop_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(rx_pop_n) <= rx_count);

    p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_out_valid && !tx_out_ready) |=> (tx_out_valid && $stable(tx_out_data)));

    p_push_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_push_n != 3'd0) && !(tx_out_valid && tx_out_ready))
        |=> (tx_count == $past(tx_count) + CW'($past(tx_push_n))));

    p_rx_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_in_valid && rx_in_ready && rx_pop_n == 3'd0)
        |=> (rx_count == $past(rx_count) + CW'(1)));

endmodule

bind bytechan_top bytechan_chk #(.DEPTH(DEPTH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rd       (bus_rd),
    .bus_rvalid   (bus_rvalid),
    .tx_out_valid (tx_out_valid),
    .tx_out_ready (tx_out_ready),
    .tx_out_data  (tx_out_data),
    .rx_in_valid  (rx_in_valid),
    .rx_in_ready  (rx_in_ready),
    .tx_count     (tx_count),
    .rx_count     (rx_count),
    .tx_push_n    (tx_push_n),
    .rx_pop_n     (rx_pop_n)
);

// File: tb/bytechan_top_tb_top.sv
module bytechan_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        tx_out_valid;
    logic        tx_out_ready = 1'b0;
    logic [7:0]  tx_out_data;
    logic        rx_in_valid = 1'b0;
    logic        rx_in_ready;
    logic [7:0]  rx_in_data = '0;
    logic        irq_tx;
    logic        irq_rx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytechan_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
        .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    localparam logic [9:0] A_PUSH1 = 10'h004, A_PUSH2 = 10'h008, A_PUSH3 = 10'h00C;
    localparam logic [9:0] A_PUSH4 = 10'h010, A_TXFREE = 10'h014;
    localparam logic [9:0] A_POP1 = 10'h01C, A_POP2 = 10'h020, A_POP3 = 10'h024;
    localparam logic [9:0] A_POP4 = 10'h028, A_RXFILL = 10'h02C;
    localparam logic [9:0] A_TXTHR = 10'h100, A_RXTHR = 10'h104;
    localparam logic [9:0] A_MASK = 10'h200, A_FLAG = 10'h204, A_STAT = 10'h208;

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check_eq("R12 rvalid after read", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    task automatic read_expect(input logic [9:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        bus_read(a, v);
        check_eq(tag, v, exp);
    endtask

    task automatic tx_take(input logic [7:0] exp, input string tag);
        check_eq({tag, " valid"}, 32'(tx_out_valid), 32'd1);
        check_eq(tag, 32'(tx_out_data), 32'(exp));
        tx_out_ready = 1'b1;
        @(negedge clk);
        tx_out_ready = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b);
        rx_in_data = b; rx_in_valid = 1'b1;
        @(negedge clk);
        rx_in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check_eq("R1 tx_out_valid", 32'(tx_out_valid), 32'd0);
        check_eq("R1 rx_in_ready", 32'(rx_in_ready), 32'd1);
        check_eq("R1 irq_tx", 32'(irq_tx), 32'd0);
        check_eq("R1 irq_rx", 32'(irq_rx), 32'd0);
        check_eq("R1 rvalid", 32'(bus_rvalid), 32'd0);
        read_expect(A_TXFREE, 32'd64, "R1 free");
        read_expect(A_RXFILL, 32'd0, "R1 fill");
        read_expect(A_MASK, 32'd0, "R1 mask");
        read_expect(A_TXTHR, 32'd1, "R1 tx threshold");
        read_expect(A_RXTHR, 32'd1, "R1 rx threshold");
        idle(1);
        check_eq("R12 rvalid drops", 32'(bus_rvalid), 32'd0);
    endtask

    task automatic t_push_widths();
        bus_write(A_PUSH1, 32'hAABBCC11);
        read_expect(A_TXFREE, 32'd63, "R4 free after 1");
        bus_write(A_PUSH2, 32'hFFEE2233);
        bus_write(A_PUSH3, 32'h99665544);
        bus_write(A_PUSH4, 32'hDDCCBBAA);
        read_expect(A_TXFREE, 32'd54, "R4 free after 10");
        check_eq("R7 held without ready", 32'(tx_out_data), 32'h11);
        tx_take(8'h11, "R2 push1 byte");
        tx_take(8'h33, "R2 push2 b0");
        tx_take(8'h22, "R2 push2 b1");
        tx_take(8'h44, "R2 push3 b0");
        tx_take(8'h55, "R2 push3 b1");
        tx_take(8'h66, "R2 push3 b2");
        tx_take(8'hAA, "R2 push4 b0");
        tx_take(8'hBB, "R2 push4 b1");
        tx_take(8'hCC, "R2 push4 b2");
        tx_take(8'hDD, "R2 push4 b3");
        check_eq("R7 empty valid", 32'(tx_out_valid), 32'd0);
        read_expect(A_TXFREE, 32'd64, "R4 free drained");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 15; i++) begin
            bus_write(A_PUSH4, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
        end
        bus_write(A_PUSH3, 32'h003E3D3C);
        read_expect(A_TXFREE, 32'd1, "R4 free at 63");
        bus_write(A_PUSH2, 32'h0000EEEE);
        read_expect(A_TXFREE, 32'd1, "R3 partial push dropped");
        read_expect(A_STAT, 32'd1, "R3 overflow sticky");
        bus_write(A_PUSH1, 32'h0000003F);
        read_expect(A_TXFREE, 32'd0, "R3 fitting push taken");
        bus_write(A_STAT, 32'd1);
        read_expect(A_STAT, 32'd0, "R3 overflow cleared");
        for (int k = 0; k < 64; k++) begin
            tx_take(8'(k), "R3 drain order");
        end
        check_eq("R3 no dropped bytes", 32'(tx_out_valid), 32'd0);
    endtask

    task automatic t_rx_pops();
        for (int k = 0; k < 10; k++) rx_send(8'(8'h10 + k));
        read_expect(A_RXFILL, 32'd10, "R4 fill");
        read_expect(A_POP1, 32'h00001001, "R5 pop1");
        read_expect(A_POP2, 32'h00121102, "R5 pop2");
        read_expect(A_POP3, 32'h15141303, "R5 pop3");
        read_expect(A_POP4, 32'h19181716, "R5 pop4");
        read_expect(A_RXFILL, 32'd0, "R4 fill empty");
        read_expect(A_STAT, 32'd0, "R6 no underflow");
    endtask

    task automatic t_underflow();
        rx_send(8'hA1);
        rx_send(8'hA2);
        read_expect(A_POP3, 32'h00A2A102, "R6 short pop3");
        read_expect(A_STAT, 32'd2, "R6 underflow sticky");
        read_expect(A_POP4, 32'h00000000, "R6 pop empty");
        rx_send(8'hB1);
        read_expect(A_POP4, 32'h000000B1, "R6 short pop4");
        read_expect(A_RXFILL, 32'd0, "R6 fill after short pops");
        bus_write(A_STAT, 32'd2);
        read_expect(A_STAT, 32'd0, "R6 underflow cleared");
    endtask

    task automatic t_rx_full();
        for (int k = 0; k < 64; k++) rx_send(8'(k ^ 8'h5A));
        check_eq("R8 ready low when full", 32'(rx_in_ready), 32'd0);
        rx_send(8'hFF);
        read_expect(A_RXFILL, 32'd64, "R8 byte refused");
        for (int w = 0; w < 16; w++) begin
            read_expect(A_POP4, {8'((4*w+3) ^ 8'h5A), 8'((4*w+2) ^ 8'h5A),
                                 8'((4*w+1) ^ 8'h5A), 8'((4*w) ^ 8'h5A)}, "R8 full drain");
        end
        check_eq("R8 ready again", 32'(rx_in_ready), 32'd1);
    endtask

    task automatic t_irq();
        bus_write(A_TXTHR, 32'd60);
        bus_write(A_RXTHR, 32'd2);
        read_expect(A_TXTHR, 32'd60, "R9 tx threshold");
        read_expect(A_RXTHR, 32'd2, "R9 rx threshold");
        bus_write(A_FLAG, 32'd3);
        idle(2);
        read_expect(A_FLAG, 32'd1, "R9 tx flag from free");
        bus_write(A_MASK, 32'd3);
        idle(2);
        check_eq("R11 irq_tx", 32'(irq_tx), 32'd1);
        check_eq("R11 irq_rx idle", 32'(irq_rx), 32'd0);
        bus_write(A_PUSH4, 32'h04030201);
        bus_write(A_PUSH4, 32'h08070605);
        idle(2);
        bus_write(A_FLAG, 32'd1);
        idle(2);
        read_expect(A_FLAG, 32'd0, "R10 tx ack cond false");
        check_eq("R11 irq_tx cleared", 32'(irq_tx), 32'd0);
        rx_send(8'hC1);
        rx_send(8'hC2);
        idle(2);
        read_expect(A_FLAG, 32'd2, "R9 rx flag from fill");
        check_eq("R11 irq_rx", 32'(irq_rx), 32'd1);
        bus_write(A_MASK, 32'd1);
        idle(1);
        check_eq("R11 irq_rx masked", 32'(irq_rx), 32'd0);
        bus_write(A_FLAG, 32'd2);
        read_expect(A_FLAG, 32'd2, "R10 ack cond holds");
        read_expect(A_POP2, 32'h00C2C102, "R5 pop in irq test");
        idle(2);
        bus_write(A_FLAG, 32'd2);
        idle(1);
        read_expect(A_FLAG, 32'd0, "R10 rx ack cond false");
        for (int k = 1; k <= 8; k++) tx_take(8'(k), "R7 irq drain");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_widths();
        t_overflow();
        t_rx_pops();
        t_underflow();
        t_rx_full();
        t_irq();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule